// File: doc/BRIEF.md
# Interrupt Context Stacking Sequencer

This block saves a small processor's register context on a byte-wide memory stack, and restores it, moving one byte per clock cycle. The context is a 16-bit program counter, two 16-bit index registers (X and Y), two 8-bit accumulators (A and B) and an 8-bit condition code register. The stack pointer starts at a 16-bit value supplied with the command. The stack grows toward lower addresses, and the pointer always names the next free byte.

Four operations are issued through a two-bit command code. Interrupt entry pushes the whole context. Interrupt return pulls the whole context. A subroutine call pushes only the program counter, which the caller supplies as the return address. A subroutine return pulls only the program counter. The block latches the command's inputs when it accepts the command. It runs the byte sequence on a single memory port, then pulses `done` and presents the resulting register values and the final stack pointer.

Top module: `ctx_stack_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_we` and `mem_re` are low and `sp_out` is 0.
- R2: A push cycle has `mem_we` high and writes the byte at address `sp_out`. The stack pointer then decrements by one at the end of that cycle.
- R3: A pull cycle has `mem_re` high and reads from address `sp_out + 1`. At the end of that cycle the stack pointer takes that address, so a pull exactly undoes a push.
- R4: Command code 0 (interrupt entry) pushes nine bytes on nine consecutive cycles in this order: PC low, PC high, Y low, Y high, X low, X high, A, B, condition codes. The final `sp_out` is the start value minus 9.
- R5: Command code 1 (interrupt return) pulls nine bytes in the reverse order: condition codes first, then B, A, X high, X low, Y high, Y low, PC high, PC low. It presents the pulled values as the outputs, and the final `sp_out` is the start value plus 9.
- R6: Command code 2 (call) pushes PC low then PC high, and the final `sp_out` is the start value minus 2. Command code 3 (return) pulls PC high then PC low, and the final `sp_out` is the start value plus 2. For both codes the X, Y, A, B and condition code outputs equal the values latched with the command.
- R7: After interrupt entry, `ccr_out` has bit 4 (the IRQ mask bit) set. The condition code byte written to the stack is the unmodified input value.
- R8: `busy` is high from the cycle after acceptance through the last byte transfer. `done` is high for exactly the following cycle, and the output registers are valid while `done` is high. Memory is accessed only while `busy` is high.
- R9: A command is accepted only while `busy` is low. A `cmd_valid` raised during a sequence, and any change of the register inputs during it, has no effect on the bytes transferred or on the results.
- R10: Stack pointer arithmetic wraps modulo 2^16 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_op | input | 2 | 0 interrupt entry, 1 interrupt return, 2 call, 3 return |
| pc_in | input | 16 | Program counter (return address for call) |
| ix_in | input | 16 | Index register X |
| iy_in | input | 16 | Index register Y |
| acca_in | input | 8 | Accumulator A |
| accb_in | input | 8 | Accumulator B |
| ccr_in | input | 8 | Condition code register |
| sp_in | input | 16 | Stack pointer at command start |
| mem_we | output | 1 | Memory write strobe for this cycle |
| mem_re | output | 1 | Memory read strobe for this cycle |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Byte written on a push |
| mem_rdata | input | 8 | Byte returned in the same cycle as `mem_re` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting program counter |
| ix_out | output | 16 | Resulting X |
| iy_out | output | 16 | Resulting Y |
| acca_out | output | 8 | Resulting A |
| accb_out | output | 8 | Resulting B |
| ccr_out | output | 8 | Resulting condition codes |
| sp_out | output | 16 | Current and final stack pointer |

## Verification
A wrong step count or slot index shows up in the same cycle as a byte on `mem_wdata` that belongs to another register, or as an address one off from the model. A stack pointer that drifts appears on `mem_addr` at the next transfer. A pull that lands in the wrong context slot only becomes visible at `done`, on the register outputs, so each save is followed by a restore that must reproduce the original values. A control state left armed after a sequence shows up one cycle after `done` as a stray `busy` or memory strobe.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

  localparam int BYTE_W   = 8;
  localparam int SLOTS    = 9;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int CCR_SLOT = SLOTS - 1;
  localparam int IMASK_BIT = 4;

  typedef enum logic [1:0] {
    OP_INT_ENTER  = 2'b00,
    OP_INT_RETURN = 2'b01,
    OP_CALL       = 2'b10,
    OP_RETURN     = 2'b11
  } stack_op_e;

  // Index of the final slot touched by an operation
  function automatic logic [SLOT_W-1:0] op_last_slot(input stack_op_e op);
    if (op == OP_INT_ENTER || op == OP_INT_RETURN)
      return SLOT_W'(SLOTS - 1);
    return SLOT_W'(1);
  endfunction

  function automatic logic op_is_pull(input stack_op_e op);
    return (op == OP_INT_RETURN) || (op == OP_RETURN);
  endfunction

  // Pushes walk slots upward; pulls walk them downward from the last one
  function automatic logic [SLOT_W-1:0] slot_for_step(input logic [SLOT_W-1:0] step,
                                                      input logic [SLOT_W-1:0] last,
                                                      input logic pull);
    return pull ? (last - step) : step;
  endfunction

  function automatic logic [15:0] sp_after(input logic [15:0] sp, input logic pull);
    return pull ? (sp + 16'd1) : (sp - 16'd1);
  endfunction

endpackage

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
  import ctx_stack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic              pull,
  output logic              xfer,
  output logic              xfer_last,
  output logic              entry_finish,
  output logic [SLOT_W-1:0] slot
);

  logic              busy_q, done_q, pull_q;
  logic [SLOT_W-1:0] step_q, last_q;
  stack_op_e         op_q;
  stack_op_e         op_in;

  assign op_in  = stack_op_e'(cmd_op);
  assign accept = cmd_valid && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pull_q <= 1'b0;
      step_q <= '0;
      last_q <= '0;
      op_q   <= OP_INT_ENTER;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= '0;
        last_q <= op_last_slot(op_in);
        pull_q <= op_is_pull(op_in);
        op_q   <= op_in;
      end else if (busy_q) begin
        if (step_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign pull         = pull_q;
  assign xfer         = busy_q;
  assign xfer_last    = busy_q && (step_q == last_q);
  assign entry_finish = xfer_last && (op_q == OP_INT_ENTER);
  assign slot         = slot_for_step(step_q, last_q, pull_q);

endmodule

// File: rtl/ctx_sp_unit.sv
module ctx_sp_unit #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic              xfer,
  input  logic              pull,
  output logic [ADDR_W-1:0] sp_q,
  output logic [ADDR_W-1:0] addr
);
  import ctx_stack_pkg::*;

  logic [ADDR_W-1:0] sp_inc;
  assign sp_inc = sp_q + ADDR_W'(1);

  // Push uses the free slot at SP; pull uses the byte above it
  assign addr = pull ? sp_inc : sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sp_q <= '0;
    else if (accept)
      sp_q <= sp_in;
    else if (xfer)
      sp_q <= pull ? sp_inc : (sp_q - ADDR_W'(1));
  end

endmodule

// File: rtl/ctx_reg_file.sv
module ctx_reg_file
  import ctx_stack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [15:0]       pc_in,
  input  logic [15:0]       ix_in,
  input  logic [15:0]       iy_in,
  input  logic [7:0]        acca_in,
  input  logic [7:0]        accb_in,
  input  logic [7:0]        ccr_in,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic [7:0]        wr_data,
  input  logic              set_imask,
  output logic [7:0]        rd_byte,
  output logic [15:0]       pc_out,
  output logic [15:0]       ix_out,
  output logic [15:0]       iy_out,
  output logic [7:0]        acca_out,
  output logic [7:0]        accb_out,
  output logic [7:0]        ccr_out
);

  logic [BYTE_W-1:0] load_v [SLOTS];
  logic [BYTE_W-1:0] ctx_q  [SLOTS];

  // Slot numbering follows the push order
  assign load_v[0] = pc_in[7:0];
  assign load_v[1] = pc_in[15:8];
  assign load_v[2] = iy_in[7:0];
  assign load_v[3] = iy_in[15:8];
  assign load_v[4] = ix_in[7:0];
  assign load_v[5] = ix_in[15:8];
  assign load_v[6] = acca_in;
  assign load_v[7] = accb_in;
  assign load_v[8] = ccr_in;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g == CCR_SLOT) begin : g_ccr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ctx_q[g] <= '0;
        else if (accept)
          ctx_q[g] <= load_v[g];
        else if (wr_en && slot == SLOT_W'(g))
          ctx_q[g] <= wr_data;
        else if (set_imask)
          ctx_q[g] <= ctx_q[g] | BYTE_W'(1 << IMASK_BIT);
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ctx_q[g] <= '0;
        else if (accept)
          ctx_q[g] <= load_v[g];
        else if (wr_en && slot == SLOT_W'(g))
          ctx_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < SLOTS; k++)
      if (slot == SLOT_W'(k)) rd_byte = ctx_q[k];
  end

  assign pc_out   = {ctx_q[1], ctx_q[0]};
  assign iy_out   = {ctx_q[3], ctx_q[2]};
  assign ix_out   = {ctx_q[5], ctx_q[4]};
  assign acca_out = ctx_q[6];
  assign accb_out = ctx_q[7];
  assign ccr_out  = ctx_q[8];

endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [15:0]       pc_in,
  input  logic [15:0]       ix_in,
  input  logic [15:0]       iy_in,
  input  logic [7:0]        acca_in,
  input  logic [7:0]        accb_in,
  input  logic [7:0]        ccr_in,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [15:0]       pc_out,
  output logic [15:0]       ix_out,
  output logic [15:0]       iy_out,
  output logic [7:0]        acca_out,
  output logic [7:0]        accb_out,
  output logic [7:0]        ccr_out,
  output logic [ADDR_W-1:0] sp_out
);
  import ctx_stack_pkg::*;

  logic              accept, pull, xfer, xfer_last, entry_finish;
  logic [SLOT_W-1:0] slot;
  logic [7:0]        rd_byte;
  logic              pull_wr;

  ctx_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .accept       (accept),
    .busy         (busy),
    .done         (done),
    .pull         (pull),
    .xfer         (xfer),
    .xfer_last    (xfer_last),
    .entry_finish (entry_finish),
    .slot         (slot)
  );

  ctx_sp_unit #(.ADDR_W(ADDR_W)) u_sp (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .sp_in  (sp_in),
    .xfer   (xfer),
    .pull   (pull),
    .sp_q   (sp_out),
    .addr   (mem_addr)
  );

  assign pull_wr = xfer && pull;

  ctx_reg_file u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .pc_in     (pc_in),
    .ix_in     (ix_in),
    .iy_in     (iy_in),
    .acca_in   (acca_in),
    .accb_in   (accb_in),
    .ccr_in    (ccr_in),
    .wr_en     (pull_wr),
    .slot      (slot),
    .wr_data   (mem_rdata),
    .set_imask (entry_finish),
    .rd_byte   (rd_byte),
    .pc_out    (pc_out),
    .ix_out    (ix_out),
    .iy_out    (iy_out),
    .acca_out  (acca_out),
    .accb_out  (accb_out),
    .ccr_out   (ccr_out)
  );

  assign mem_we    = xfer && !pull;
  assign mem_re    = pull_wr;
  assign mem_wdata = mem_we ? rd_byte : 8'h00;

endmodule

// File: rtl/ctx_stack_seq_chk.sv
module ctx_stack_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              busy,
  input logic              done,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] sp_out,
  input logic [7:0]        ccr_out,
  input logic              xfer_last,
  input logic              entry_finish
);

  assert_push_at_sp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr == sp_out);

  assert_push_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp_out == $past(sp_out) - ADDR_W'(1));

  assert_pull_above_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> mem_addr == sp_out + ADDR_W'(1));

  assert_pull_moves_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp_out == $past(mem_addr));

  assert_imask_after_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    entry_finish |=> ccr_out[4]);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_follows_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_last |=> done && !busy);

  assert_access_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy && !(mem_we && mem_re));

  assert_busy_ignores_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && !xfer_last) |=> busy && !done);

endmodule

bind ctx_stack_seq ctx_stack_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .busy         (busy),
  .done         (done),
  .mem_we       (mem_we),
  .mem_re       (mem_re),
  .mem_addr     (mem_addr),
  .sp_out       (sp_out),
  .ccr_out      (ccr_out),
  .xfer_last    (xfer_last),
  .entry_finish (entry_finish)
);

// File: tb/ctx_stack_seq_test.sv
module ctx_stack_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [15:0] pc_in = '0, ix_in = '0, iy_in = '0, sp_in = '0;
  logic [7:0]  acca_in = '0, accb_in = '0, ccr_in = '0;
  logic        mem_we, mem_re, busy, done;
  logic [15:0] mem_addr, pc_out, ix_out, iy_out, sp_out;
  logic [7:0]  mem_wdata, mem_rdata, acca_out, accb_out, ccr_out;

  logic [7:0] mem [256];
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  ctx_stack_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .pc_in(pc_in), .ix_in(ix_in), .iy_in(iy_in), .acca_in(acca_in),
    .accb_in(accb_in), .ccr_in(ccr_in), .sp_in(sp_in),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .pc_out(pc_out), .ix_out(ix_out), .iy_out(iy_out), .acca_out(acca_out),
    .accb_out(accb_out), .ccr_out(ccr_out), .sp_out(sp_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Issue one command and compare against a queue-based model every cycle
  task automatic run_cmd(input logic [1:0] op, input logic [15:0] pc, ix, iy,
                         input logic [7:0] a, b, cc, input logic [15:0] sp,
                         input bit noise, input string req);
    byte unsigned ctx[$];
    byte unsigned res[9];
    bit   is_pull = (op == 2'd1) || (op == 2'd3);
    int   nbytes  = (op[1] == 1'b0) ? 9 : 2;
    logic [15:0] exp_sp;
    ctx = '{pc[7:0], pc[15:8], iy[7:0], iy[15:8], ix[7:0], ix[15:8], a, b, cc};
    foreach (ctx[i]) res[i] = ctx[i];
    @(negedge clk);
    cmd_op = op; cmd_valid = 1'b1;
    pc_in = pc; ix_in = ix; iy_in = iy; acca_in = a; accb_in = b; ccr_in = cc; sp_in = sp;
    exp_sp = sp;
    @(negedge clk);
    for (int i = 0; i < nbytes; i++) begin
      chk(busy === 1'b1, "R8", "busy during transfer", 32'(busy), 32'd1);
      if (!is_pull) begin
        chk(mem_we === 1'b1 && mem_re === 1'b0, "R2", "push strobe", {mem_we, mem_re}, 2'b10);
        chk(mem_addr === exp_sp, "R2", "push address", mem_addr, exp_sp);
        chk(mem_wdata === ctx[i], req, "pushed byte", mem_wdata, ctx[i]);
        exp_sp = exp_sp - 16'd1;
      end else begin
        exp_sp = exp_sp + 16'd1;
        chk(mem_re === 1'b1 && mem_we === 1'b0, "R3", "pull strobe", {mem_we, mem_re}, 2'b01);
        chk(mem_addr === exp_sp, "R3", "pull address", mem_addr, exp_sp);
        res[nbytes - 1 - i] = mem[exp_sp[7:0]];
      end
      if (noise) begin
        cmd_valid = 1'b1; cmd_op = ~op;
        pc_in = 16'hDEAD; ix_in = 16'hBEEF; iy_in = 16'hCAFE;
        acca_in = 8'h5A; accb_in = 8'hA5; ccr_in = 8'hFF; sp_in = 16'h7777;
      end else begin
        cmd_valid = 1'b0;
      end
      if (i == nbytes - 1) cmd_valid = 1'b0;
      @(negedge clk);
    end
    if (op == 2'd0) res[8] = res[8] | 8'h10;
    chk(done === 1'b1 && busy === 1'b0, "R8", "done pulse", {done, busy}, 2'b10);
    chk(mem_we === 1'b0 && mem_re === 1'b0, "R8", "no access at done", {mem_we, mem_re}, 2'b00);
    chk(sp_out === exp_sp, (sp > exp_sp && is_pull) || (sp < exp_sp && !is_pull) ? "R10" : req,
        "final sp", sp_out, exp_sp);
    chk(pc_out === {res[1], res[0]}, req, "pc_out", pc_out, {res[1], res[0]});
    chk(iy_out === {res[3], res[2]}, req, "iy_out", iy_out, {res[3], res[2]});
    chk(ix_out === {res[5], res[4]}, req, "ix_out", ix_out, {res[5], res[4]});
    chk(acca_out === res[6] && accb_out === res[7], req, "acc out",
        {acca_out, accb_out}, {res[6], res[7]});
    chk(ccr_out === res[8], (op == 2'd0) ? "R7" : req, "ccr_out", ccr_out, res[8]);
    if (noise) chk(pc_out === {res[1], res[0]}, "R9", "busy command ignored", pc_out, {res[1], res[0]});
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R8", "done one cycle", {done, busy}, 2'b00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0 && done === 1'b0, "R1", "reset busy/done", {busy, done}, 2'b00);
    chk(mem_we === 1'b0 && mem_re === 1'b0, "R1", "reset strobes", {mem_we, mem_re}, 2'b00);
    chk(sp_out === 16'h0000, "R1", "reset sp", sp_out, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 entry then R5 restore of the same context
    run_cmd(2'd0, 16'h8123, 16'h4567, 16'h89AB, 8'h11, 8'h22, 8'h05, 16'h01F0, 1'b0, "R4");
    run_cmd(2'd1, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0, 16'h01E7, 1'b0, "R5");
    chk(ccr_out === 8'h05, "R5", "restored ccr unmasked", ccr_out, 8'h05);

    // R6 call and return with R9 noise during the sequence
    run_cmd(2'd2, 16'h1234, 16'h0A0A, 16'h0B0B, 8'h33, 8'h44, 8'h81, 16'h0180, 1'b1, "R6");
    run_cmd(2'd3, 16'h0000, 16'h0C0C, 16'h0D0D, 8'h55, 8'h66, 8'h02, 16'h017E, 1'b1, "R6");
    chk(pc_out === 16'h1234, "R6", "returned pc", pc_out, 16'h1234);

    // R5 from a preloaded frame: ccr, B, A, XH, XL, YH, YL, PCH, PCL upward
    mem[8'h51] = 8'hC4; mem[8'h52] = 8'h9B; mem[8'h53] = 8'h7A;
    mem[8'h54] = 8'h12; mem[8'h55] = 8'h34; mem[8'h56] = 8'h56;
    mem[8'h57] = 8'h78; mem[8'h58] = 8'h9A; mem[8'h59] = 8'hBC;
    run_cmd(2'd1, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0, 16'h0050, 1'b1, "R5");
    chk(ix_out === 16'h1234 && iy_out === 16'h5678, "R5", "frame index regs",
        {ix_out, iy_out}, 32'h12345678);
    chk(pc_out === 16'h9ABC && acca_out === 8'h7A && accb_out === 8'h9B, "R5", "frame pc/acc",
        {pc_out, acca_out, accb_out}, {16'h9ABC, 8'h7A, 8'h9B});

    // R10 wrap through zero on entry and back on return
    run_cmd(2'd0, 16'hFEDC, 16'h0102, 16'h0304, 8'hE1, 8'hE2, 8'hD0, 16'h0003, 1'b1, "R4");
    chk(sp_out === 16'hFFFA, "R10", "entry wrap sp", sp_out, 16'hFFFA);
    run_cmd(2'd1, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0, 16'hFFFA, 1'b0, "R5");
    chk(sp_out === 16'h0003 && pc_out === 16'hFEDC, "R10", "return wrap sp/pc",
        {sp_out, pc_out}, {16'h0003, 16'hFEDC});

    repeat (2) @(negedge clk);
    summary();
  end

endmodule